// File: doc/BRIEF.md
# Precision-Time Clock Servo (PI Loop with Lock Hysteresis)

This block closes the frequency loop of a precision-time follower. Once per sync interval it receives a signed measurement of how far the local wallclock is from the time leader, in nanoseconds. The offset is defined as leader time minus local time, so a positive value means the local clock is behind. The block passes the measurement through a proportional-integral filter and returns a signed frequency correction in parts per billion. A positive correction speeds the local clock up. The wallclock logic applies that correction.

The gains are powers of two, so no multiplier is needed. Each gain is an arithmetic right shift. The current base-2 logarithm of the sync interval is added to both shift amounts, so that the per-update correction follows the interval length. A lock flag with separate acquire and release thresholds tells the rest of the system when the loop has settled.

A built-in gain and threshold set applies by default. A runtime tuning port can load a new set, but only while dynamic tuning is enabled.

Top module: `ptp_servo_pi`

## Requirements
- R1: For each accepted sample, P = offset >>> sp and the integrator gains offset >>> si, where >>> is an arithmetic (floor) shift. The correction is P plus the updated integrator value.
- R2: The shift amounts are sp = kp_shift + log_interval and si = ki_shift + log_interval. log_interval is an 8-bit two's-complement value. Each sum is limited to the range 0 to 31.
- R3: After the increment is added, the integrator is clamped to ±int_bound, where int_bound is a 32-bit unsigned number.
- R4: The correction saturates to the range -500000 to +500000 ppb (PPB_LIMIT).
- R5: A sample whose absolute offset is strictly below the lock threshold sets the locked flag.
- R6: A sample whose absolute offset is strictly above the unlock threshold clears the locked flag. A sample whose absolute offset lies between the two thresholds, boundaries included, keeps the previous lock state.
- R7: ppb_valid pulses high for exactly one cycle, in the cycle after sample_valid. Without a sample, the correction, the integrator and the lock flag keep their values.
- R8: A synchronous high rst clears the integrator, drops lock, drives a zero correction and restores the default tuning set.
- R9: A tune_wr while tune_dyn_en is high loads the tuning set. While tune_dyn_en is low, the defaults apply and tune_wr is ignored, so a later enable brings back the last set loaded while enabled.
- R10: The default set is kp_shift 2, ki_shift 4, lock threshold 500 ns, unlock threshold 5000 ns and integrator bound 20000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_valid | input | 1 | Offset sample strobe |
| sample_offset | input | 32 | Signed offset in ns (leader minus local) |
| log_interval | input | 8 | Signed log2 of the sync interval |
| tune_dyn_en | input | 1 | Dynamic tuning enable |
| tune_wr | input | 1 | Load strobe for the tuning set |
| tune_kp_shift | input | 5 | Proportional shift to load |
| tune_ki_shift | input | 5 | Integral shift to load |
| tune_lock_ns | input | 32 | Lock-acquire threshold to load |
| tune_unlock_ns | input | 32 | Lock-release threshold to load |
| tune_int_bound | input | 32 | Integrator clamp to load |
| ppb_out | output | 32 | Signed frequency correction in ppb |
| ppb_valid | output | 1 | Correction strobe |
| locked | output | 1 | Lock flag |

## Verification
The bench uses the default parameters. The integrator bound of 20000 is small, so two full-scale offsets drive the integrator onto both clamp rails. The same full-scale offsets push the sum past the ±500000 saturation, so R3 and R4 are reached within a handful of samples. The logarithmic interval is driven at 2, at -3 and at 40, which covers both ends of the shift clamp. The lock thresholds of 500 and 5000 are probed exactly at and one step beyond each boundary. Through the tuning port, the bench loads kp_shift 0 and a tight bound of 1000, and checks that writes made while dynamic tuning is off have no effect.

// File: rtl/ptp_servo_pkg.sv
package ptp_servo_pkg;
    localparam int OFS_W  = 32;
    localparam int LOG_W  = 8;
    localparam int SH_W   = 5;
    localparam int THR_W  = 32;
    localparam int PPB_W  = 32;
    localparam int ACC_W  = THR_W + 2;
    localparam int MAX_SH = OFS_W - 1;

    typedef logic signed [OFS_W-1:0] offset_t;
    typedef logic signed [LOG_W-1:0] log_t;

    typedef struct packed {
        logic [SH_W-1:0]  kp_sh;
        logic [SH_W-1:0]  ki_sh;
        logic [THR_W-1:0] lock_thr;
        logic [THR_W-1:0] unlock_thr;
        logic [THR_W-1:0] int_bound;
    } tune_set_t;

    typedef enum logic [1:0] {
        LK_HOLD    = 2'd0,
        LK_ACQUIRE = 2'd1,
        LK_RELEASE = 2'd2
    } lock_evt_t;

    // base shift plus signed interval log, limited to [0, MAX_SH]
    function automatic logic [SH_W-1:0] scaled_shift(input logic [SH_W-1:0] base,
                                                     input log_t lg);
        logic signed [LOG_W+1:0] sum;
        sum = $signed({{(LOG_W+2-SH_W){1'b0}}, base}) + $signed({{2{lg[LOG_W-1]}}, lg});
        if (sum < 0)
            return '0;
        else if (sum > $signed((LOG_W+2)'(MAX_SH)))
            return SH_W'(MAX_SH);
        else
            return sum[SH_W-1:0];
    endfunction

    function automatic logic [OFS_W:0] magnitude(input offset_t v);
        logic signed [OFS_W:0] e;
        e = {v[OFS_W-1], v};
        return (e < 0) ? (OFS_W+1)'(-e) : (OFS_W+1)'(e);
    endfunction
endpackage

// File: rtl/ptp_servo_tune.sv
module ptp_servo_tune
    import ptp_servo_pkg::*;
#(
    parameter tune_set_t DEFAULTS = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      dyn_en,
    input  logic      wr,
    input  tune_set_t wr_set,
    output tune_set_t active
);
    tune_set_t loaded;

    always_ff @(posedge clk) begin
        if (rst)
            loaded <= DEFAULTS;
        else if (wr && dyn_en)
            loaded <= wr_set;
    end

    assign active = dyn_en ? loaded : DEFAULTS;

    // R9: with dynamic tuning off, writes leave the loaded set untouched
    a_r9_static_ignores_writes: assert property (@(posedge clk) disable iff (rst)
        !dyn_en |=> $stable(loaded));
endmodule

// File: rtl/ptp_servo_gain.sv
module ptp_servo_gain
    import ptp_servo_pkg::*;
(
    input  logic [SH_W-1:0] kp_base,
    input  logic [SH_W-1:0] ki_base,
    input  log_t            log_int,
    output logic [SH_W-1:0] kp_eff,
    output logic [SH_W-1:0] ki_eff
);
    localparam int LANES = 2;
    logic [SH_W-1:0] base_arr [LANES];
    logic [SH_W-1:0] eff_arr  [LANES];

    assign base_arr[0] = kp_base;
    assign base_arr[1] = ki_base;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign eff_arr[g] = scaled_shift(base_arr[g], log_int);
    end

    assign kp_eff = eff_arr[0];
    assign ki_eff = eff_arr[1];
endmodule

// File: rtl/ptp_servo_lock.sv
module ptp_servo_lock
    import ptp_servo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sample_valid,
    input  offset_t          offset,
    input  logic [THR_W-1:0] lock_thr,
    input  logic [THR_W-1:0] unlock_thr,
    output logic             locked
);
    logic [OFS_W:0] mag;
    lock_evt_t      evt;

    always_comb begin
        mag = magnitude(offset);
        if (mag < {1'b0, lock_thr})
            evt = LK_ACQUIRE;
        else if (mag > {1'b0, unlock_thr})
            evt = LK_RELEASE;
        else
            evt = LK_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst)
            locked <= 1'b0;
        else if (sample_valid) begin
            case (evt)
                LK_ACQUIRE: locked <= 1'b1;
                LK_RELEASE: locked <= 1'b0;
                default:    locked <= locked;
            endcase
        end
    end

    // R5: small offset acquires lock
    a_r5_acquire: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && magnitude(offset) < {1'b0, lock_thr}) |=> locked);
    // R6: large offset drops lock
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && magnitude(offset) > {1'b0, unlock_thr}
         && !(magnitude(offset) < {1'b0, lock_thr})) |=> !locked);
    // R7: no sample, lock unchanged
    a_r7_lock_hold: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> $stable(locked));
endmodule

// File: rtl/ptp_servo_pi_core.sv
module ptp_servo_pi_core
    import ptp_servo_pkg::*;
#(
    parameter int PPB_LIMIT = 500000
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_valid,
    input  offset_t                 offset,
    input  logic [SH_W-1:0]         sp,
    input  logic [SH_W-1:0]         si,
    input  logic [THR_W-1:0]        bound,
    output logic signed [PPB_W-1:0] ppb_out,
    output logic                    ppb_valid
);
    localparam logic signed [ACC_W:0]   LIM_W = (ACC_W+1)'(PPB_LIMIT);
    localparam logic signed [PPB_W-1:0] LIM_P = PPB_W'(PPB_LIMIT);

    logic signed [ACC_W-1:0] integ;
    offset_t                 p_term, i_inc;
    logic signed [ACC_W:0]   p_x, i_x, integ_x, sum_i, bnd, integ_nx, total, ppb_nx;

    always_comb begin
        p_term  = offset >>> sp;
        i_inc   = offset >>> si;
        p_x     = {{(ACC_W+1-OFS_W){p_term[OFS_W-1]}}, p_term};
        i_x     = {{(ACC_W+1-OFS_W){i_inc[OFS_W-1]}}, i_inc};
        integ_x = {integ[ACC_W-1], integ};
        bnd     = {{(ACC_W+1-THR_W){1'b0}}, bound};
        sum_i   = integ_x + i_x;
        if (sum_i > bnd)
            integ_nx = bnd;
        else if (sum_i < -bnd)
            integ_nx = -bnd;
        else
            integ_nx = sum_i;
        total = integ_nx + p_x;
        if (total > LIM_W)
            ppb_nx = LIM_W;
        else if (total < -LIM_W)
            ppb_nx = -LIM_W;
        else
            ppb_nx = total;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            integ     <= '0;
            ppb_out   <= '0;
            ppb_valid <= 1'b0;
        end else begin
            ppb_valid <= sample_valid;
            if (sample_valid) begin
                integ   <= integ_nx[ACC_W-1:0];
                ppb_out <= ppb_nx[PPB_W-1:0];
            end
        end
    end

    // R7: strobe follows a sample by one cycle and lasts one cycle
    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> ppb_valid);
    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> !ppb_valid);
    // R7: state held between samples
    a_r7_integ_hold: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> ($stable(integ) && $stable(ppb_out)));
    // R4: correction within the saturation range
    a_r4_ppb_range: assert property (@(posedge clk) disable iff (rst)
        (ppb_out <= LIM_P) && (ppb_out >= -LIM_P));
endmodule

// File: rtl/ptp_servo_pi.sv
module ptp_servo_pi
    import ptp_servo_pkg::*;
#(
    parameter int DEF_KP_SHIFT  = 2,
    parameter int DEF_KI_SHIFT  = 4,
    parameter int DEF_LOCK_NS   = 500,
    parameter int DEF_UNLOCK_NS = 5000,
    parameter int DEF_INT_BOUND = 20000,
    parameter int PPB_LIMIT     = 500000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_valid,
    input  logic signed [OFS_W-1:0]  sample_offset,
    input  logic signed [LOG_W-1:0]  log_interval,
    input  logic                     tune_dyn_en,
    input  logic                     tune_wr,
    input  logic [SH_W-1:0]          tune_kp_shift,
    input  logic [SH_W-1:0]          tune_ki_shift,
    input  logic [THR_W-1:0]         tune_lock_ns,
    input  logic [THR_W-1:0]         tune_unlock_ns,
    input  logic [THR_W-1:0]         tune_int_bound,
    output logic signed [PPB_W-1:0]  ppb_out,
    output logic                     ppb_valid,
    output logic                     locked
);
    localparam tune_set_t DEFAULTS = '{
        kp_sh:      SH_W'(DEF_KP_SHIFT),
        ki_sh:      SH_W'(DEF_KI_SHIFT),
        lock_thr:   THR_W'(DEF_LOCK_NS),
        unlock_thr: THR_W'(DEF_UNLOCK_NS),
        int_bound:  THR_W'(DEF_INT_BOUND)
    };

    tune_set_t       wr_set, active;
    logic [SH_W-1:0] sp, si;

    assign wr_set = '{
        kp_sh:      tune_kp_shift,
        ki_sh:      tune_ki_shift,
        lock_thr:   tune_lock_ns,
        unlock_thr: tune_unlock_ns,
        int_bound:  tune_int_bound
    };

    ptp_servo_tune #(.DEFAULTS(DEFAULTS)) tune_i (
        .clk    (clk),
        .rst    (rst),
        .dyn_en (tune_dyn_en),
        .wr     (tune_wr),
        .wr_set (wr_set),
        .active (active)
    );

    ptp_servo_gain gain_i (
        .kp_base (active.kp_sh),
        .ki_base (active.ki_sh),
        .log_int (log_interval),
        .kp_eff  (sp),
        .ki_eff  (si)
    );

    ptp_servo_pi_core #(.PPB_LIMIT(PPB_LIMIT)) core_i (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .offset       (sample_offset),
        .sp           (sp),
        .si           (si),
        .bound        (active.int_bound),
        .ppb_out      (ppb_out),
        .ppb_valid    (ppb_valid)
    );

    ptp_servo_lock lock_i (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .offset       (sample_offset),
        .lock_thr     (active.lock_thr),
        .unlock_thr   (active.unlock_thr),
        .locked       (locked)
    );

    // R8: reset leaves a quiet, unlocked, zero output
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (ppb_out == '0 && !ppb_valid && !locked));
endmodule

// File: tb/ptp_servo_pi_tb.sv
module ptp_servo_pi_tb_top;
    logic               clk = 1'b0;
    logic               rst;
    logic               sample_valid;
    logic signed [31:0] sample_offset;
    logic signed [7:0]  log_interval;
    logic               tune_dyn_en, tune_wr;
    logic [4:0]         tune_kp_shift, tune_ki_shift;
    logic [31:0]        tune_lock_ns, tune_unlock_ns, tune_int_bound;
    logic signed [31:0] ppb_out;
    logic               ppb_valid, locked;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    ptp_servo_pi dut_i (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .sample_offset(sample_offset), .log_interval(log_interval),
        .tune_dyn_en(tune_dyn_en), .tune_wr(tune_wr),
        .tune_kp_shift(tune_kp_shift), .tune_ki_shift(tune_ki_shift),
        .tune_lock_ns(tune_lock_ns), .tune_unlock_ns(tune_unlock_ns),
        .tune_int_bound(tune_int_bound),
        .ppb_out(ppb_out), .ppb_valid(ppb_valid), .locked(locked)
    );

    // Default gains: P = off>>>(2+log), I += off>>>(4+log), bound 20000
    localparam int NV = 16;
    localparam int V_OFS [NV] = '{8000, 4000, 400, -3000, -6000, -17, 1024, 1024,
                                  -2000000000, -2147483647-1, 2147483647, 0,
                                  499, 500, -5000, 5001};
    localparam int V_LOG [NV] = '{0, 0, 0, 0, 0, 0, 2, -3, 40, 0, 0, 0, 0, 0, 0, 0};
    localparam int V_PPB [NV] = '{2500, 1750, 875, -163, -1288, 205, 290, 1762,
                                  736, -500000, 500000, 20000, 20124, 20125,
                                  18437, 21249};
    localparam int V_LCK [NV] = '{0, 0, 1, 1, 0, 1, 1, 1, 0, 0, 0, 1, 1, 1, 1, 0};
    localparam string V_TAG [NV] = '{"R1", "R6", "R5", "R1", "R6", "R1", "R2",
                                     "R2", "R2", "R3", "R4", "R3", "R5", "R6",
                                     "R6", "R6"};

    task automatic check_int(string tag, string what, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // drives one sample; returns at the negedge after the capturing edge
    task automatic send(int ofs, int lg);
        @(negedge clk);
        sample_valid  = 1'b1;
        sample_offset = 32'(ofs);
        log_interval  = 8'(lg);
        @(negedge clk);
        sample_valid  = 1'b0;
    endtask

    task automatic check_out(string tag, int ppb, int lck);
        check_int(tag, "ppb_out", int'(ppb_out), ppb);
        check_int(tag, "locked", int'(locked), lck);
        check_int("R7", "ppb_valid high", int'(ppb_valid), 1);
    endtask

    task automatic load_tune(int kp, int ki, int lk, int ulk, int bnd);
        @(negedge clk);
        tune_wr        = 1'b1;
        tune_kp_shift  = 5'(kp);
        tune_ki_shift  = 5'(ki);
        tune_lock_ns   = 32'(lk);
        tune_unlock_ns = 32'(ulk);
        tune_int_bound = 32'(bnd);
        @(negedge clk);
        tune_wr = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sample_valid = 1'b0; sample_offset = '0; log_interval = '0;
        tune_dyn_en = 1'b0; tune_wr = 1'b0; tune_kp_shift = '0; tune_ki_shift = '0;
        tune_lock_ns = '0; tune_unlock_ns = '0; tune_int_bound = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        check_int("R8", "ppb_out after reset", int'(ppb_out), 0);
        check_int("R8", "locked after reset", int'(locked), 0);
        check_int("R8", "ppb_valid after reset", int'(ppb_valid), 0);

        // R10 defaults, vector walk
        for (int i = 0; i < NV; i++) begin
            send(V_OFS[i], V_LOG[i]);
            check_out(V_TAG[i], V_PPB[i], V_LCK[i]);
        end

        // R7 single-cycle strobe and hold without samples
        @(negedge clk);
        check_int("R7", "ppb_valid drops", int'(ppb_valid), 0);
        sample_offset = 32'(-99999);
        repeat (3) @(negedge clk);
        check_int("R7", "ppb_out held", int'(ppb_out), 21249);
        check_int("R7", "locked held", int'(locked), 0);

        // R8 reset mid-run clears integrator and lock
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_int("R8", "ppb_out cleared", int'(ppb_out), 0);
        check_int("R8", "lock cleared", int'(locked), 0);
        send(16, 0);
        check_out("R8", 5, 1);

        // R9 write while static is ignored
        load_tune(0, 0, 10, 20, 5);
        send(64, 0);
        check_out("R9", 21, 1);
        tune_dyn_en = 1'b1;
        send(64, 0);
        check_out("R9", 25, 1);

        // R9 dynamic load takes effect
        load_tune(0, 3, 100, 200, 1000);
        send(150, 0);
        check_out("R9", 177, 1);
        send(250, 0);
        check_out("R6", 308, 0);
        send(100000, 0);
        check_out("R3", 101000, 0);

        // R10 defaults return when dynamic tuning is disabled
        tune_dyn_en = 1'b0;
        send(0, 0);
        check_out("R10", 1000, 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule